// File: doc/BRIEF.md
# Dual-Trigger Non-Retriggerable Pulse Stretcher

This block is a clocked monostable. It watches two trigger pins of opposite polarity and one active-low clear pin. All three are asynchronous to the block clock and are brought in through synchronizer chains. When it sees a qualifying edge, it drives `pulse_q` high for a programmed number of clock cycles, and it drives `pulse_qn` with the inverse. A pulse that has started runs to its end and cannot be extended. Only the clear pin can cut it short.

The active-low trigger fires on its falling edge, but only while the active-high trigger is high. The active-high trigger fires on its rising edge, but only while the active-low trigger is low. A third start condition exists. The clear pin must be held low while the triggers first leave their armed levels and then return to them. The later release of the clear pin then starts a pulse by itself. The pulse length is sampled when the pulse starts, so the driver may change it at any time.

Top module: `osh_oneshot`

## Requirements
- R1: After `rst_n` is released, and before any trigger, `pulse_q` is 0 and `pulse_qn` is 1.
- R2: A 1-to-0 change of `trig_a_n` while `trig_b` = 1 and `clear_n` = 1 starts a pulse. Input changes reach `pulse_q` on the third rising clock edge after the change (two synchronizer stages plus the output register). A falling `trig_a_n` while `trig_b` = 0 starts nothing.
- R3: A 0-to-1 change of `trig_b` while `trig_a_n` = 0 and `clear_n` = 1 starts a pulse, with the same latency as R2.
- R4: While a pulse is running, edges on `trig_a_n` and `trig_b` neither restart it nor lengthen it.
- R5: A low level on `clear_n` drops `pulse_q` three clock edges after the change, whatever the state of the count. No trigger is accepted while the synchronized clear is low.
- R6: `pulse_q` stays high for exactly `pulse_len` cycles. The value is taken at the start, and later changes do not alter a running pulse.
- R7: A `pulse_len` of 0 yields a pulse of one cycle.
- R8: The clear release starts a pulse when two conditions hold. During the clear, `trig_a_n` = 1 or `trig_b` = 0 was seen first, and then `trig_a_n` = 0 and `trig_b` = 1. At the release, `trig_a_n` = 0 and `trig_b` = 1.
- R9: A clear release without that sequence (the triggers stay at `trig_a_n` = 0, `trig_b` = 1 throughout the clear) starts nothing.
- R10: A trigger that qualifies in the last cycle of a pulse is ignored. A trigger that qualifies one cycle later starts a new pulse right after a single low cycle.
- R11: `pulse_qn` is the complement of `pulse_q` on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| trig_a_n | input | 1 | Falling-edge trigger, asynchronous |
| trig_b | input | 1 | Rising-edge trigger, asynchronous |
| clear_n | input | 1 | Clear, active low, asynchronous; release can trigger |
| pulse_len | input | LEN_W (16) | Pulse length in clock cycles, sampled at start |
| pulse_q | output | 1 | Pulse output, active high |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
The bench targets the last cycle of a pulse. It lands one trigger exactly there and another one cycle later. A design that checks for expiry one cycle late would accept the first trigger, and an off-by-one counter would merge or drop the second pulse. Both trigger pins are toggled in the middle of a pulse while the length input changes. A retriggerable design would show a longer pulse, and one that reads the length live would show a shorter one. For clear release, the bench compares a release after a full arming sequence with a release where the triggers simply sat at their armed levels. A design that fires on any release with the triggers armed would produce a pulse the scoreboard never expected. A zero length must give one cycle, not a counter wrap to 65536.

// File: rtl/osh_pkg.sv
package osh_pkg;

   // synchronized view of the three asynchronous pins
   typedef struct packed {
      logic a_n;
      logic b;
      logic clr_n;
   } osh_pins_t;

   // reset image: triggers parked at armed levels, clear asserted,
   // so no edge and no arming step is implied by the reset itself
   localparam osh_pins_t OSH_SYNC_RST = '{a_n: 1'b0, b: 1'b1, clr_n: 1'b0};

endpackage

// File: rtl/osh_sync.sv
module osh_sync
   import osh_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  osh_pins_t pins,
   output osh_pins_t cur,
   output osh_pins_t prev
);
   localparam int W = $bits(osh_pins_t);

   logic [STAGES:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){W'(OSH_SYNC_RST)}};
      else        chain <= {chain[STAGES-1:0], W'(pins)};
   end

   assign cur  = osh_pins_t'(chain[STAGES-1]);
   assign prev = osh_pins_t'(chain[STAGES]);
endmodule

// File: rtl/osh_trig_qual.sv
module osh_trig_qual
   import osh_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  osh_pins_t cur,
   input  osh_pins_t prev,
   output logic      fire
);
   logic disarmed_seen;
   logic a_fall, b_rise, clr_rel;

   // arming record for the clear-release start: set when a trigger
   // leaves its armed level while the clear is held, dropped on release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                disarmed_seen <= 1'b0;
      else if (cur.clr_n)        disarmed_seen <= 1'b0;
      else if (cur.a_n || !cur.b) disarmed_seen <= 1'b1;
   end

   assign a_fall  = prev.a_n && !cur.a_n && cur.b && cur.clr_n;
   assign b_rise  = !prev.b && cur.b && !cur.a_n && cur.clr_n;
   assign clr_rel = !prev.clr_n && cur.clr_n && !cur.a_n && cur.b && disarmed_seen;
   assign fire    = a_fall || b_rise || clr_rel;
endmodule

// File: rtl/osh_timer.sv
module osh_timer #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             fire,
   input  logic [LEN_W-1:0] len,
   output logic             active,
   output logic [LEN_W-1:0] remain
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] len_eff;
   assign len_eff = (len == '0) ? ONE : len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         remain <= '0;
      end else if (clr) begin
         active <= 1'b0;
         remain <= '0;
      end else if (active) begin
         if (remain <= ONE) begin
            active <= 1'b0;
            remain <= '0;
         end else begin
            remain <= remain - ONE;
         end
      end else if (fire) begin
         active <= 1'b1;
         remain <= len_eff;
      end
   end
endmodule

// File: rtl/osh_oneshot.sv
module osh_oneshot
   import osh_pkg::*;
#(
   parameter int LEN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_a_n,
   input  logic             trig_b,
   input  logic             clear_n,
   input  logic [LEN_W-1:0] pulse_len,
   output logic             pulse_q,
   output logic             pulse_qn
);
   generate
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("osh_oneshot: LEN_W must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("osh_oneshot: SYNC_STAGES must be at least 2");
      end
   endgenerate

   osh_pins_t        pins_raw, s_cur, s_prev;
   logic             fire_w, clr_live, active_w;
   logic [LEN_W-1:0] remain_w;

   assign pins_raw = '{a_n: trig_a_n, b: trig_b, clr_n: clear_n};

   osh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .pins (pins_raw),
      .cur (s_cur), .prev (s_prev)
   );

   osh_trig_qual u_qual (
      .clk (clk), .rst_n (rst_n), .cur (s_cur), .prev (s_prev),
      .fire (fire_w)
   );

   assign clr_live = s_cur.clr_n;

   osh_timer #(.LEN_W(LEN_W)) u_timer (
      .clk (clk), .rst_n (rst_n), .clr (!clr_live), .fire (fire_w),
      .len (pulse_len), .active (active_w), .remain (remain_w)
   );

   assign pulse_q  = active_w;
   assign pulse_qn = !active_w;
endmodule

// File: rtl/osh_oneshot_chk.sv
module osh_oneshot_chk #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_live,
   input logic             fire,
   input logic [LEN_W-1:0] remain,
   input logic [LEN_W-1:0] len,
   input logic             q
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   // R5
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_live |=> !q);

   // R4
   no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && clr_live && remain > ONE) |=> (q && remain == $past(remain) - ONE));

   // R6
   len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !q && clr_live) |=>
         (q && remain == (($past(len) == '0) ? ONE : $past(len))));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !fire) |=> !q);

   // R10
   expiry_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && remain == ONE) |=> !q);
endmodule

bind osh_oneshot osh_oneshot_chk #(.LEN_W(LEN_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .clr_live (clr_live), .fire (fire_w),
   .remain (remain_w), .len (pulse_len), .q (pulse_q)
);

// File: tb/sim_osh_oneshot.sv
`timescale 1ns/1ps
module sim_osh_oneshot;
   localparam int LEN_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_a_n = 1'b1, trig_b = 1'b1, clear_n = 1'b0;
   logic [LEN_W-1:0] pulse_len = 16'd5;
   logic pulse_q, pulse_qn;

   always #4 clk = ~clk;   // 125 MHz

   osh_oneshot #(.LEN_W(LEN_W)) u0 (
      .clk (clk), .rst_n (rst_n), .trig_a_n (trig_a_n), .trig_b (trig_b),
      .clear_n (clear_n), .pulse_len (pulse_len),
      .pulse_q (pulse_q), .pulse_qn (pulse_qn)
   );

   typedef struct { int start; int width; string req; } exp_t;
   exp_t sb[$];

   int cyc = 0, checks = 0, fails = 0, pushed = 0, seen = 0;
   bit in_pulse = 1'b0, done = 1'b0;
   int p_start = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push(input int start, input int width, input string req);
      exp_t e;
      e.start = start; e.width = width; e.req = req;
      sb.push_back(e);
      pushed++;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: complement check every cycle, pulse extraction and compare
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(pulse_qn === ~pulse_q, "R11", int'(pulse_qn), int'(~pulse_q));
         if (pulse_q && !in_pulse) begin
            in_pulse = 1'b1;
            p_start  = cyc;
         end else if (!pulse_q && in_pulse) begin
            in_pulse = 1'b0;
            seen++;
            if (sb.size() == 0) begin
               chk(1'b0, "R9 unexpected pulse", p_start, -1);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(p_start == e.start, {e.req, " start"}, p_start, e.start);
               chk(cyc - p_start == e.width, {e.req, " width"}, cyc - p_start, e.width);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8ns * 200000);
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      int c;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk(pulse_q === 1'b0, "R1 q", int'(pulse_q), 0);
      chk(pulse_qn === 1'b1, "R1 qn", int'(pulse_qn), 1);
      clear_n = 1'b1;
      step(5);

      // R2: A falls with B high
      pulse_len = 16'd5;
      c = cyc; trig_a_n = 1'b0; push(c + 3, 5, "R2");
      step(12); trig_a_n = 1'b1; step(3);

      // R2: A falls with B low -> nothing
      trig_b = 1'b0; step(3);
      trig_a_n = 1'b0; step(8);
      trig_a_n = 1'b1; step(3);

      // R3: B rises with A low
      trig_a_n = 1'b0; step(3);
      pulse_len = 16'd3;
      c = cyc; trig_b = 1'b1; push(c + 3, 3, "R3");
      step(8); trig_a_n = 1'b1; step(3);

      // R4 / R6: retrigger and length change inside a pulse
      pulse_len = 16'd10;
      c = cyc; trig_a_n = 1'b0; push(c + 3, 10, "R4 R6");
      step(4); trig_a_n = 1'b1; pulse_len = 16'd2;
      step(1); trig_b = 1'b0;
      step(1); trig_a_n = 1'b0; trig_b = 1'b1;
      step(12); trig_a_n = 1'b1; step(3);

      // R5: clear cuts a pulse, triggers blocked while clear low
      pulse_len = 16'd20;
      c = cyc; trig_a_n = 1'b0; push(c + 3, 8, "R5");
      step(8); clear_n = 1'b0;
      step(3); trig_a_n = 1'b1;
      step(3); trig_a_n = 1'b0;      // fall during clear: ignored, arms release
      step(4);
      chk(pulse_q === 1'b0, "R5 held", int'(pulse_q), 0);

      // R8: armed release fires
      pulse_len = 16'd4;
      c = cyc; clear_n = 1'b1; push(c + 3, 4, "R8");
      step(10);

      // R9: plain release without arming sequence
      clear_n = 1'b0; step(6);
      clear_n = 1'b1; step(8);
      chk(seen == pushed, "R9 count", seen, pushed);

      // R7: zero length gives one cycle
      trig_a_n = 1'b1; step(3);
      pulse_len = 16'd0;
      c = cyc; trig_a_n = 1'b0; push(c + 3, 1, "R7");
      step(6); trig_a_n = 1'b1; step(3);

      // R10: trigger in the expiry cycle is ignored
      pulse_len = 16'd4;
      c = cyc; trig_a_n = 1'b0; push(c + 3, 4, "R10");
      step(2); trig_a_n = 1'b1;
      step(2); trig_a_n = 1'b0;
      step(10); trig_a_n = 1'b1; step(3);

      // R10: trigger one cycle later is accepted
      c = cyc; trig_a_n = 1'b0; push(c + 3, 4, "R10 first");
      step(2); trig_a_n = 1'b1;
      step(3); trig_a_n = 1'b0; push(c + 8, 4, "R10 next");
      step(12); trig_a_n = 1'b1; step(5);

      chk(sb.size() == 0, "R6 missing pulses", sb.size(), 0);
      chk(seen == pushed, "R4 pulse count", seen, pushed);
      finish_run();
   end
endmodule